// File: doc/BRIEF.md
# Shared-Bus Fetch and Load/Store Sequencer

This block is the front end of a small 32-bit load/store processor whose instructions and data live in one asynchronous SRAM behind a single bus. It holds the program counter and the instruction register. It decodes just enough of the current instruction to pick the bus address for the next edge. For ALU and branch instructions that address is the next instruction. For a load or store it is the operand address supplied by the datapath.

A load or store therefore spends one cycle on its data transfer and one on the fetch that follows. Multiply and divide hold the sequencer for a fixed busy window. An external stall from the bus arbiter freezes everything. The read strobe is active low. The write strobe is active low and combined with the clock, so a write can only fall in the low half of a cycle, when the address has settled. Load data is captured and handed to the register file with a one-cycle valid pulse.

Addresses are word addresses. The program counter steps by one.

Top module: `shb_fetch_seq`

## Requirements
- R1: While reset is held and in the first cycle after release, `pc_o` is 0, `ir_o` holds the no-op (all zeros), `addr_o` is 0 with `rd_no` low, and `ld_valid_o` and `busy_o` are low.
- R2: An ALU instruction has opcode bits [31:30] equal to 00 or 01 and a function field in bits [19:16] other than 1010 or 1011. It takes one cycle: `addr_o` equals `pc_o`, the next edge loads the fetched word into `ir_o`, and `pc_o` advances by one.
- R3: A memory instruction has opcode 10, and bit 29 set marks a store. In its first cycle `addr_o` equals `data_addr_i`. In its second cycle `addr_o` returns to the next instruction, so it completes in two cycles.
- R4: The word read at the load address appears on `ld_data_o`, with `ld_valid_o` high for exactly one unstalled cycle: the load's second cycle. `ir_o` is not reloaded at the edge that starts that cycle.
- R5: For a store, `rd_no` is high in its first cycle and `wr_no` goes low in the low half of that cycle only. `rd_no` is low in every other unstalled cycle.
- R6: An ALU-class instruction whose function field is 1010 (multiply) or 1011 (divide) keeps `busy_o` high and `ir_o` unchanged so that it occupies MDU_CYCLES (32) unstalled cycles in total.
- R7: A branch has opcode 11. When `br_taken_i` is high, `addr_o` becomes `br_target_i` in the same cycle and `pc_o` becomes the target plus one after the edge, with no extra cycle. When `br_taken_i` is low, the fetch is sequential.
- R8: While `stall_i` is high, the PC, the IR, the phase and the multiply/divide count do not change, both strobes stay high, and `ld_valid_o` is low. The total cycle count grows by exactly the number of stalled cycles.
- R9: `wr_no` is never low while the clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; also gates the write strobe |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | External stall from the bus arbiter |
| rdata_i | input | XLEN | Read data from the shared memory |
| data_addr_i | input | AW | Operand address computed by the datapath |
| br_taken_i | input | 1 | Branch condition from the datapath |
| br_target_i | input | AW | Branch target from the datapath |
| addr_o | output | AW | Shared bus address |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low, high whenever the clock is high |
| ir_o | output | XLEN | Instruction register |
| pc_o | output | AW | Next sequential fetch address |
| ld_data_o | output | XLEN | Captured load data |
| ld_valid_o | output | 1 | Load writeback valid pulse |
| busy_o | output | 1 | Multiply/divide busy window |

## Verification
The assertions assume that `stall_i` changes only early in the high half of the clock. This keeps the strobes settled before the low half, where the write can occur. They also assume that `data_addr_i`, `br_target_i` and `br_taken_i` are combinational functions of the instruction register. The bench drives stall shortly after each rising edge and derives the operand address and branch target from `ir_o`, the way a datapath would. Its random programs hold only ALU, multiply/divide, load and store instructions, so every run is straight-line code. Branches are covered by directed cases.

// File: rtl/shb_seq_pkg.sv
`timescale 1ns/100ps
package shb_seq_pkg;
  typedef enum logic [1:0] {
    OPC_ALU_R = 2'b00,
    OPC_ALU_I = 2'b01,
    OPC_MEM   = 2'b10,
    OPC_BR    = 2'b11
  } opc_e;

  typedef enum logic {
    PH_EXEC = 1'b0,
    PH_DATA = 1'b1
  } phase_e;

  typedef struct packed {
    logic mem;
    logic store;
    logic branch;
    logic mdu;
  } dec_t;

  localparam logic [3:0] FN_MUL = 4'b1010;
  localparam logic [3:0] FN_DIV = 4'b1011;
endpackage

// File: rtl/shb_seq_decode.sv
`timescale 1ns/100ps
module shb_seq_decode
  import shb_seq_pkg::*;
(
  input  logic [1:0] opc_i,
  input  logic       store_i,
  input  logic [3:0] fn_i,
  output dec_t       dec_o
);
  opc_e opc;
  assign opc = opc_e'(opc_i);

  always_comb begin
    dec_o = '0;
    case (opc)
      OPC_ALU_R, OPC_ALU_I: dec_o.mdu = (fn_i == FN_MUL) || (fn_i == FN_DIV);
      OPC_MEM: begin
        dec_o.mem   = 1'b1;
        dec_o.store = store_i;
      end
      OPC_BR:  dec_o.branch = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/shb_seq_mdu_timer.sv
`timescale 1ns/100ps
module shb_seq_mdu_timer #(
  parameter int CYCLES = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic adv_i,
  output logic busy_o
);
  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  // busy until the last counted cycle; the IR reloads at the end of it
  assign busy_o = req_i && (cnt_q != LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (req_i && adv_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/shb_seq_addr_sel.sv
`timescale 1ns/100ps
module shb_seq_addr_sel #(
  parameter int AW = 32
) (
  input  logic          data_sel_i,
  input  logic          br_sel_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] data_addr_i,
  input  logic [AW-1:0] br_target_i,
  output logic [AW-1:0] addr_o
);
  always_comb begin
    if (data_sel_i)    addr_o = data_addr_i;
    else if (br_sel_i) addr_o = br_target_i;
    else               addr_o = pc_i;
  end
endmodule

// File: rtl/shb_fetch_seq.sv
`timescale 1ns/100ps
module shb_fetch_seq
  import shb_seq_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              AW         = 32,
  parameter int              MDU_CYCLES = 32,
  parameter int              FN_LO      = 16,
  parameter logic [XLEN-1:0] NOP_INSN   = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stall_i,
  input  logic [XLEN-1:0] rdata_i,
  input  logic [AW-1:0]   data_addr_i,
  input  logic            br_taken_i,
  input  logic [AW-1:0]   br_target_i,
  output logic [AW-1:0]   addr_o,
  output logic            rd_no,
  output logic            wr_no,
  output logic [XLEN-1:0] ir_o,
  output logic [AW-1:0]   pc_o,
  output logic [XLEN-1:0] ld_data_o,
  output logic            ld_valid_o,
  output logic            busy_o
);
  localparam int OPC_LO = XLEN - 2;
  localparam int ST_BIT = XLEN - 3;
  localparam int FN_HI  = FN_LO + 3;

  logic [XLEN-1:0] ir_q, ld_q;
  logic [AW-1:0]   pc_q;
  phase_e          ph_q;
  dec_t            dec;
  logic            in_data, issue_data, take_br, mdu_busy, wr_req;

  shb_seq_decode u_dec (
    .opc_i   (ir_q[XLEN-1:OPC_LO]),
    .store_i (ir_q[ST_BIT]),
    .fn_i    (ir_q[FN_HI:FN_LO]),
    .dec_o   (dec)
  );

  shb_seq_mdu_timer #(.CYCLES(MDU_CYCLES)) u_mdu (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (dec.mdu),
    .adv_i  (~stall_i),
    .busy_o (mdu_busy)
  );

  assign in_data    = (ph_q == PH_DATA);
  assign issue_data = dec.mem && !in_data;
  assign take_br    = dec.branch && br_taken_i;

  shb_seq_addr_sel #(.AW(AW)) u_addr (
    .data_sel_i  (issue_data),
    .br_sel_i    (take_br),
    .pc_i        (pc_q),
    .data_addr_i (data_addr_i),
    .br_target_i (br_target_i),
    .addr_o      (addr_o)
  );

  assign wr_req = issue_data && dec.store;

  // strobes idle while the bus belongs to another master
  assign rd_no = wr_req || stall_i;
  // write lands only in the low half of the cycle
  assign wr_no = !(wr_req && !stall_i) || clk_i;

  assign ld_valid_o = in_data && !dec.store && !stall_i;
  assign ld_data_o  = ld_q;
  assign ir_o       = ir_q;
  assign pc_o       = pc_q;
  assign busy_o     = mdu_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q <= NOP_INSN;
      pc_q <= '0;
      ph_q <= PH_EXEC;
      ld_q <= '0;
    end else if (!stall_i) begin
      if (issue_data) begin
        ph_q <= PH_DATA;
        if (!dec.store) ld_q <= rdata_i;
      end else if (!mdu_busy) begin
        ir_q <= rdata_i;
        pc_q <= addr_o + AW'(1);
        ph_q <= PH_EXEC;
      end
    end
  end
endmodule

// File: rtl/shb_fetch_seq_chk.sv
`timescale 1ns/100ps
module shb_fetch_seq_chk #(
  parameter int XLEN       = 32,
  parameter int AW         = 32,
  parameter int MDU_CYCLES = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            stall_i,
  input logic            rd_no,
  input logic            wr_no,
  input logic            ld_valid_o,
  input logic            busy_o,
  input logic [XLEN-1:0] ir_o,
  input logic [AW-1:0]   pc_o
);
  localparam int RW = $clog2(MDU_CYCLES + 1) + 1;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 run_q <= '0;
    else if (!busy_o)            run_q <= '0;
    else if (!stall_i)           run_q <= run_q + 1'b1;
  end

  // R9
  wr_hi_phase_chk: assert property (@(negedge clk_i) disable iff (!rst_ni) wr_no == 1'b1);

  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> ($stable(ir_o) && $stable(pc_o)));

  // R4
  ld_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o |=> !ld_valid_o);

  // R4
  ld_keep_ir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o |-> $stable(ir_o));

  // R5
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> wr_no);

  // R6
  mdu_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !stall_i) |=> $stable(ir_o));

  // R6
  mdu_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q < RW'(MDU_CYCLES));
endmodule

bind shb_fetch_seq shb_fetch_seq_chk #(
  .XLEN(XLEN), .AW(AW), .MDU_CYCLES(MDU_CYCLES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stall_i    (stall_i),
  .rd_no      (rd_no),
  .wr_no      (wr_no),
  .ld_valid_o (ld_valid_o),
  .busy_o     (busy_o),
  .ir_o       (ir_o),
  .pc_o       (pc_o)
);

// File: tb/shb_fetch_seq_tb.sv
`timescale 1ns/100ps
module shb_fetch_seq_tb;
  localparam int XLEN = 32;
  localparam int AW   = 32;
  localparam int MDUC = 32;
  localparam logic [31:0] MARK = 32'h0ACE_0001;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            stall_i = 1'b0;
  logic            br_taken_i = 1'b0;
  logic [XLEN-1:0] rdata_i;
  logic [AW-1:0]   data_addr_i, br_target_i, addr_o, pc_o;
  logic            rd_no, wr_no, ld_valid_o, busy_o;
  logic [XLEN-1:0] ir_o, ld_data_o;

  logic [31:0] mem [0:255];
  int checks = 0, fails = 0;
  int wr_cnt = 0;
  logic [AW-1:0] last_wr;

  always #2.5 clk_i = ~clk_i;

  shb_fetch_seq #(.XLEN(XLEN), .AW(AW), .MDU_CYCLES(MDUC)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .stall_i(stall_i), .rdata_i(rdata_i),
    .data_addr_i(data_addr_i), .br_taken_i(br_taken_i), .br_target_i(br_target_i),
    .addr_o(addr_o), .rd_no(rd_no), .wr_no(wr_no), .ir_o(ir_o), .pc_o(pc_o),
    .ld_data_o(ld_data_o), .ld_valid_o(ld_valid_o), .busy_o(busy_o)
  );

  // datapath stand-in and one-cycle asynchronous RAM
  assign rdata_i     = mem[addr_o[7:0]];
  assign data_addr_i = (ir_o[29] ? AW'(192) : AW'(128)) + AW'(ir_o[5:0]);
  assign br_target_i = AW'(ir_o[7:0]);

  function automatic logic [31:0] store_val(logic [AW-1:0] a);
    return 32'h5700_0000 | 32'(a[7:0]);
  endfunction

  function automatic logic [31:0] init_val(int a);
    return (a >= 128) ? (32'hD000_0000 | 32'(a)) : 32'h0;
  endfunction

  always @(negedge wr_no) begin
    wr_cnt++;
    last_wr = addr_o;
    mem[addr_o[7:0]] = store_val(addr_o);
  end

  function automatic logic [31:0] mk_alu(logic [31:0] r);
    return {2'b01, r[29:20], 4'(r[19:16] % 10), r[15:0]};
  endfunction
  function automatic logic [31:0] mk_mem(bit st, logic [5:0] off);
    return {2'b10, st, 23'h0, off};
  endfunction
  function automatic logic [31:0] mk_mdu(bit dv, logic [31:0] r);
    return {2'b00, r[9:0], 3'b101, dv, r[31:16]};
  endfunction
  function automatic logic [31:0] mk_br(logic [7:0] t);
    return {2'b11, 22'h0, t};
  endfunction
  function automatic int cost(logic [31:0] i);
    if (i[31:30] == 2'b10) return 2;
    if (i[31] == 1'b0 && (i[19:16] == 4'b1010 || i[19:16] == 4'b1011)) return MDUC;
    return 1;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int a = 0; a < 256; a++) mem[a] = init_val(a);
  endtask

  task automatic start();
    rst_ni = 1'b0; stall_i = 1'b0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    wr_cnt = 0;
  endtask

  task automatic nxt();
    @(posedge clk_i); #1.5;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lds, sts, exp_cyc, stalls, got, ld_bad, hi_low;
    logic [31:0] ins;
    void'($urandom(32'd4711));

    // R1 reset state
    clear_mem();
    rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    #1;
    chk("R1 pc", pc_o, 0);
    chk("R1 ir", ir_o, 0);
    chk("R1 addr", addr_o, 0);
    chk("R1 rd_no", 32'(rd_no), 0);
    chk("R1 ld_valid", 32'(ld_valid_o), 0);
    chk("R1 busy", 32'(busy_o), 0);
    @(negedge clk_i); rst_ni = 1'b1; #1;
    chk("R1 first fetch addr", addr_o, 0);
    chk("R1 first fetch rd", 32'(rd_no), 0);

    // R2 ALU sequence
    clear_mem();
    for (int k = 0; k < 3; k++) mem[k] = mk_alu($urandom);
    mem[3] = MARK;
    start();
    for (int k = 1; k <= 3; k++) begin
      nxt();
      chk("R2 ir", ir_o, mem[k-1]);
      chk("R2 addr", addr_o, k);
      chk("R2 pc", pc_o, k);
    end
    nxt(); chk("R2 mark", ir_o, MARK);

    // R3/R4 load
    clear_mem();
    mem[0] = mk_mem(1'b0, 6'd5); mem[1] = MARK;
    start();
    nxt();
    chk("R3 ld data addr", addr_o, 133);
    chk("R3 ld rd", 32'(rd_no), 0);
    chk("R4 no early valid", 32'(ld_valid_o), 0);
    nxt();
    chk("R4 valid", 32'(ld_valid_o), 1);
    chk("R4 data", ld_data_o, 32'hD000_0085);
    chk("R4 ir kept", ir_o, mem[0]);
    chk("R3 fetch resumes", addr_o, 1);
    nxt();
    chk("R3 mark", ir_o, MARK);
    chk("R4 pulse ends", 32'(ld_valid_o), 0);

    // R8 stall in the load data phase
    start();
    nxt(); nxt();
    stall_i = 1'b1; #0.2;
    chk("R8 valid held low", 32'(ld_valid_o), 0);
    chk("R8 rd idle", 32'(rd_no), 1);
    nxt();
    chk("R8 ir held", ir_o, mem[0]);
    chk("R8 pc held", pc_o, 1);
    stall_i = 1'b0; #0.2;
    chk("R8 valid after stall", 32'(ld_valid_o), 1);
    nxt();
    chk("R8 mark", ir_o, MARK);

    // R5/R9 store
    clear_mem();
    mem[0] = mk_mem(1'b1, 6'd3); mem[1] = MARK;
    start();
    nxt();
    chk("R3 st data addr", addr_o, 195);
    chk("R5 st rd idle", 32'(rd_no), 1);
    chk("R9 high phase", 32'(wr_no), 1);
    @(negedge clk_i); #0.5;
    chk("R5 st low phase", 32'(wr_no), 0);
    nxt();
    chk("R5 next rd", 32'(rd_no), 0);
    chk("R3 st fetch", addr_o, 1);
    @(negedge clk_i); #0.5;
    chk("R5 no second write", 32'(wr_no), 1);
    chk("R5 write count", 32'(wr_cnt), 1);
    chk("R5 write addr", last_wr, 195);
    chk("R5 mem", mem[195], store_val(195));
    nxt();
    chk("R3 st mark", ir_o, MARK);

    // R6 multiply
    clear_mem();
    mem[0] = mk_mdu(1'b0, $urandom); mem[1] = MARK;
    start();
    got = 0;
    for (int c = 1; c <= 60; c++) begin
      nxt();
      if (c == 1)    chk("R6 busy start", 32'(busy_o), 1);
      if (c == MDUC - 1) chk("R6 busy last", 32'(busy_o), 1);
      if (c == MDUC) chk("R6 busy end", 32'(busy_o), 0);
      if (ir_o == MARK) begin got = c; break; end
    end
    chk("R6 mul cycles", got, 1 + MDUC);

    // R7 branch taken and not taken
    clear_mem();
    mem[0] = mk_br(8'd10); mem[1] = mk_alu(32'h1); mem[10] = MARK;
    br_taken_i = 1'b1;
    start();
    nxt();
    chk("R7 target addr", addr_o, 10);
    nxt();
    chk("R7 taken ir", ir_o, MARK);
    chk("R7 taken pc", pc_o, 11);
    br_taken_i = 1'b0;
    mem[1] = MARK;
    start();
    nxt();
    chk("R7 not taken addr", addr_o, 1);
    nxt();
    chk("R7 not taken ir", ir_o, MARK);

    // random straight-line programs, second round with stalls
    for (int rnd = 0; rnd < 3; rnd++) begin
      clear_mem();
      lds = 0; sts = 0; exp_cyc = 1;
      for (int k = 0; k < 40; k++) begin
        case ($urandom % 8)
          0, 1, 2, 3: ins = mk_alu($urandom);
          4: begin ins = mk_mem(1'b0, 6'($urandom)); lds++; end
          5: begin ins = mk_mem(1'b1, 6'($urandom)); sts++; end
          6: ins = mk_mdu(1'b0, $urandom);
          default: ins = mk_mdu(1'b1, $urandom);
        endcase
        mem[k] = ins;
        exp_cyc += cost(ins);
      end
      mem[40] = MARK;
      start();
      stalls = 0; got = 0; ld_bad = 0; hi_low = 0;
      for (int c = 1; c <= 4000; c++) begin
        nxt();
        if (!wr_no) hi_low++;
        if (ir_o == MARK) begin got = c; break; end
        stall_i = (rnd > 0) && (($urandom % 4) == 0);
        if (stall_i) stalls++;
        #0.2;
        if (ld_valid_o) begin
          lds--;
          if (ld_data_o !== init_val(int'(data_addr_i[7:0]))) ld_bad++;
        end
      end
      stall_i = 1'b0;
      chk("R8 total cycles", got, exp_cyc + stalls);
      chk("R4 load pulses", lds, 0);
      chk("R4 load data", ld_bad, 0);
      chk("R5 store writes", wr_cnt, sts);
      chk("R9 high-phase writes", hi_low, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule